// File: doc/BRIEF.md
# Two-Port Packet Route Switch

The block takes a stream of byte-serial packets on a single input and steers each packet to output port 0, output port 1, or both. The steering rule is chosen by a small set of write-only configuration registers. One rule compares the packet's address byte with a filter address under a bit mask. Another tests whether the packet's length falls inside an inclusive window. A third copies every packet to both ports, and with filtering off everything goes to port 0. When a filter rule applies, a packet that satisfies it goes to port 1 and a packet that fails it goes to port 0.

The first byte of a packet is its address and the second byte is its total length in bytes, counting both header bytes. The bytes of one packet arrive on consecutive valid cycles, and a new packet may follow in the very next cycle. The routing decision can be made once the length byte is in. The block holds the bytes in a small ring store and plays each packet out with its valid held high for exactly its length. The output runs one cycle behind the input, so back-to-back input packets leave back to back.

Top module: `pkt_route_switch`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, both output valids are low. After reset the mode register is 0, so a packet sent without any configuration leaves on port 0 only.
- R2: Mode code 0 (filtering off) sends every packet to port 0 only. Any mode code other than 1, 2 or 4 behaves the same way.
- R3: Mode code 4 sends every packet to both ports with identical bytes in the same cycles.
- R4: Mode code 1 sends a packet to port 1 when (address byte AND mask) equals (filter address AND mask), and to port 0 otherwise. A mask of 0 therefore matches every address.
- R5: Mode code 2 sends a packet to port 1 when lower limit <= length byte <= upper limit, with both bounds inclusive, and to port 0 otherwise.
- R6: Byte 0 of a packet is the address and byte 1 is the total length L (3 to 31). The selected port shows valid for exactly L consecutive cycles and carries the bytes in arrival order. The first byte appears on the clock edge that samples the length byte.
- R7: The mode and the filter values are taken when a packet's first byte is accepted. A register write that lands later within that packet does not change that packet's routing, but it does apply to the following packet.
- R8: A register write takes one cycle with `cfg_we` high. Register index 0 is the mode, 2 the filter address, 3 the filter mask, 4 the lower length limit and 5 the upper length limit. A write to index 1, 6 or 7 changes nothing.
- R9: Packets that arrive with no idle cycle between them leave with no idle cycle between them, and each one is routed by its own header and the configuration in force at its first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input packet byte |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | ADDR_W (3) | Register index |
| cfg_wdata | input | 8 | Register write value |
| out0_valid | output | 1 | Port 0 byte present |
| out0_data | output | 8 | Port 0 byte |
| out1_valid | output | 1 | Port 1 byte present |
| out1_data | output | 8 | Port 1 byte |

## Verification
Two situations are the hardest to reach from the ports. The first is a register write whose strobe lands in the middle of a packet. The second is a run of packets with no idle cycle between them, where one packet's last byte leaves in the same cycle that the next packet's length byte arrives. The stimulus task raises the write strobe on the third byte of a packet and then checks where that packet and the next one go. It also sends random bursts of packets with zero gap, comparing the full byte stream on each port against a queue built by the bench's own routing function. Directed packets sit exactly on the length-window bounds and just outside them, and mask cases cover both a full match and a zero mask.

// File: rtl/pfs_pkg.sv
`timescale 1ns/1ps
package pfs_pkg;
   localparam int BYTE_W = 8;

   // mode codes held in the mode register
   localparam int MODE_OFF  = 0;
   localparam int MODE_ADDR = 1;
   localparam int MODE_LEN  = 2;
   localparam int MODE_BOTH = 4;

   // register indices on the write port
   localparam int REG_MODE  = 0;
   localparam int REG_FADDR = 2;
   localparam int REG_FMASK = 3;
   localparam int REG_LO    = 4;
   localparam int REG_HI    = 5;

   typedef struct packed {
      logic [BYTE_W-1:0] mode;
      logic [BYTE_W-1:0] faddr;
      logic [BYTE_W-1:0] fmask;
      logic [BYTE_W-1:0] len_lo;
      logic [BYTE_W-1:0] len_hi;
   } cfg_t;
endpackage

// File: rtl/pfs_cfg_regs.sv
`timescale 1ns/1ps
module pfs_cfg_regs
   import pfs_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [BYTE_W-1:0] wdata,
   output cfg_t              cfg
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr_w
         $error("pfs_cfg_regs: ADDR_W must reach index 5");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (we) begin
         case (int'(waddr))
            REG_MODE:  cfg.mode   <= wdata;
            REG_FADDR: cfg.faddr  <= wdata;
            REG_FMASK: cfg.fmask  <= wdata;
            REG_LO:    cfg.len_lo <= wdata;
            REG_HI:    cfg.len_hi <= wdata;
            default:   ;
         endcase
      end
   end

   // R8: a mode write is visible on the following cycle
   a_r8_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(waddr) == REG_MODE) |=> (cfg.mode == $past(wdata)));
endmodule

// File: rtl/pfs_route.sv
`timescale 1ns/1ps
module pfs_route
   import pfs_pkg::*;
(
   input  cfg_t              snap,
   input  logic [BYTE_W-1:0] pkt_addr,
   input  logic [BYTE_W-1:0] pkt_len,
   output logic              to_p0,
   output logic              to_p1
);
   logic hit_addr;
   logic hit_len;

   always_comb begin
      hit_addr = ((pkt_addr & snap.fmask) == (snap.faddr & snap.fmask));
      hit_len  = (pkt_len >= snap.len_lo) && (pkt_len <= snap.len_hi);
      case (int'(snap.mode))
         MODE_ADDR: begin to_p1 = hit_addr; to_p0 = !hit_addr; end
         MODE_LEN:  begin to_p1 = hit_len;  to_p0 = !hit_len;  end
         MODE_BOTH: begin to_p1 = 1'b1;     to_p0 = 1'b1;      end
         default:   begin to_p1 = 1'b0;     to_p0 = 1'b1;      end
      endcase
   end
endmodule

// File: rtl/pfs_byte_ring.sv
`timescale 1ns/1ps
module pfs_byte_ring
   import pfs_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int PTR_W = $clog2(DEPTH);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pfs_byte_ring: DEPTH must be a power of two, at least 4");
      end
   endgenerate

   logic [PTR_W-1:0]             wptr;
   logic [PTR_W-1:0]             rptr;
   logic [DEPTH-1:0][BYTE_W-1:0] cells;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk) begin
            if (wr_en && wptr == PTR_W'(i)) q <= wr_data;
         end
         assign cells[i] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (wr_en) wptr <= wptr + 1'b1;
         if (rd_en) rptr <= rptr + 1'b1;
      end
   end

   assign rd_data = cells[rptr];

   // R6: the play-out side never reads a slot that has not been filled
   a_r6_read_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rptr != wptr));
endmodule

// File: rtl/pkt_route_switch.sv
`timescale 1ns/1ps
module pkt_route_switch
   import pfs_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DEPTH   = 32,
   parameter int MIN_LEN = 3,
   parameter int MAX_LEN = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [BYTE_W-1:0] cfg_wdata,
   output logic              out0_valid,
   output logic [BYTE_W-1:0] out0_data,
   output logic              out1_valid,
   output logic [BYTE_W-1:0] out1_data
);
   generate
      if (MIN_LEN < 3 || MAX_LEN < MIN_LEN || MAX_LEN >= (1 << BYTE_W)) begin : g_bad_len
         $error("pkt_route_switch: length bounds out of range");
      end
   endgenerate

   typedef enum logic [1:0] {RX_IDLE, RX_LEN, RX_BODY} rx_st_t;

   cfg_t              cfg;
   cfg_t              snap;
   rx_st_t            rx_st;
   logic [BYTE_W-1:0] addr_q;
   logic [BYTE_W-1:0] len_q;
   logic [BYTE_W-1:0] cnt;
   logic [BYTE_W-1:0] tx_left;
   logic [1:0]        route_q;
   logic              dec_p0;
   logic              dec_p1;
   logic              len_byte;
   logic              load;
   logic [BYTE_W-1:0] rd_data;
   logic [BYTE_W-1:0] o_data;
   logic              o_v0;
   logic              o_v1;

   pfs_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .waddr (cfg_addr),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   pfs_route u_route (
      .snap     (snap),
      .pkt_addr (addr_q),
      .pkt_len  (in_data),
      .to_p0    (dec_p0),
      .to_p1    (dec_p1)
   );

   pfs_byte_ring #(.DEPTH(DEPTH)) u_ring (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (in_valid),
      .wr_data (in_data),
      .rd_en   (load),
      .rd_data (rd_data)
   );

   assign len_byte = in_valid && (rx_st == RX_LEN);
   assign load     = len_byte || (tx_left != '0);

   // receive framing: header capture and byte count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_st  <= RX_IDLE;
         snap   <= '0;
         addr_q <= '0;
         len_q  <= '0;
         cnt    <= '0;
      end else if (in_valid) begin
         case (rx_st)
            RX_IDLE: begin
               snap   <= cfg;
               addr_q <= in_data;
               rx_st  <= RX_LEN;
            end
            RX_LEN: begin
               len_q <= in_data;
               cnt   <= BYTE_W'(2);
               rx_st <= (in_data > BYTE_W'(2)) ? RX_BODY : RX_IDLE;
            end
            RX_BODY: begin
               if (cnt == len_q - 1'b1) rx_st <= RX_IDLE;
               else                     cnt   <= cnt + 1'b1;
            end
            default: rx_st <= RX_IDLE;
         endcase
      end
   end

   // play-out: starts on the length byte, runs for the packet length
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_left <= '0;
         route_q <= '0;
         o_data  <= '0;
         o_v0    <= 1'b0;
         o_v1    <= 1'b0;
      end else begin
         if (len_byte) begin
            route_q <= {dec_p1, dec_p0};
            tx_left <= (in_data == '0) ? '0 : in_data - 1'b1;
         end else if (tx_left != '0) begin
            tx_left <= tx_left - 1'b1;
         end
         if (load) begin
            o_data <= rd_data;
            o_v0   <= len_byte ? dec_p0 : route_q[0];
            o_v1   <= len_byte ? dec_p1 : route_q[1];
         end else begin
            o_v0 <= 1'b0;
            o_v1 <= 1'b0;
         end
      end
   end

   assign out0_valid = o_v0;
   assign out1_valid = o_v1;
   assign out0_data  = o_data;
   assign out1_data  = o_data;

   // R6: output activity begins only on a length byte
   a_r6_start_after_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out0_valid || out1_valid) |-> $past(len_byte));
   // R6: output activity ends only once the remaining count is spent
   a_r6_run_ends_drained: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out0_valid || out1_valid) |-> ($past(tx_left) == '0 && !$past(len_byte)));
   // R6: header length byte lies within the supported range
   a_r6_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      len_byte |-> (in_data >= BYTE_W'(MIN_LEN) && in_data <= BYTE_W'(MAX_LEN)));
   // R7: the configuration snapshot holds for the body of a packet
   a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_st == RX_BODY) |-> $stable(snap));
   // R9: a new packet's play-out never overlaps the previous one
   a_r9_tx_drained: assert property (@(posedge clk) disable iff (!rst_n)
      len_byte |-> (tx_left == '0));
endmodule

// File: tb/pkt_route_switch_bench.sv
`timescale 1ns/1ps
module pkt_route_switch_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       out0_valid, out1_valid;
   logic [7:0] out0_data, out1_data;

   pkt_route_switch u_pkt_route_switch (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .out0_valid(out0_valid), .out0_data(out0_data),
      .out1_valid(out1_valid), .out1_data(out1_data));

   always #10 clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   int m_mode = 0, m_fa = 0, m_fm = 0, m_lo = 0, m_hi = 0;
   int exp0[$], exp1[$], got0[$], got1[$];
   int run0[$], run1[$], erun0[$], erun1[$];
   int cur0 = 0, cur1 = 0;

   always @(negedge clk) begin
      if (out0_valid) begin got0.push_back(int'(out0_data)); cur0++; end
      else if (cur0 != 0) begin run0.push_back(cur0); cur0 = 0; end
      if (out1_valid) begin got1.push_back(int'(out1_data)); cur1++; end
      else if (cur1 != 0) begin run1.push_back(cur1); cur1 = 0; end
   end

   task automatic chk(bit ok, string tag, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // 1 = port 0, 2 = port 1, 3 = both
   function automatic int route_of(int mode, int fa, int fm, int lo, int hi, int a, int l);
      case (mode)
         1: return ((a & fm) == (fa & fm)) ? 2 : 1;
         2: return (l >= lo && l <= hi) ? 2 : 1;
         4: return 3;
         default: return 1;
      endcase
   endfunction

   task automatic model_wr(int a, int d);
      case (a)
         0: m_mode = d;
         2: m_fa = d;
         3: m_fm = d;
         4: m_lo = d;
         5: m_hi = d;
         default: ;
      endcase
   endtask

   task automatic wr(int a, int d);
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = d[7:0];
      @(negedge clk);
      cfg_we = 1'b0;
      model_wr(a, d);
   endtask

   task automatic send(int a, int len, int gap, int mid_a = -1, int mid_d = 0, bit tchk = 0);
      int r;
      int b;
      r = route_of(m_mode, m_fa, m_fm, m_lo, m_hi, a, len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (tchk && i == 1)
            chk(!(out0_valid || out1_valid), "R6 idle before length edge",
                int'(out0_valid || out1_valid), 0);
         if (tchk && i == 2) begin
            chk(out0_valid == r[0] && out1_valid == r[1], "R6 first byte on length edge",
                {out1_valid, out0_valid}, r);
            chk(((r & 1) ? out0_data : out1_data) == a[7:0], "R6 first byte is address",
                int'((r & 1) ? out0_data : out1_data), a);
         end
         b = (i == 0) ? a : (i == 1) ? len : int'($urandom_range(0, 255));
         in_valid = 1'b1; in_data = b[7:0];
         if (i == 2 && mid_a >= 0) begin
            cfg_we = 1'b1; cfg_addr = mid_a[2:0]; cfg_wdata = mid_d[7:0];
         end else begin
            cfg_we = 1'b0;
         end
         if (r & 1) exp0.push_back(b);
         if (r & 2) exp1.push_back(b);
      end
      if (r & 1) erun0.push_back(len);
      if (r & 2) erun1.push_back(len);
      if (mid_a >= 0) model_wr(mid_a, mid_d);
      if (gap > 0) begin
         @(negedge clk);
         in_valid = 1'b0; cfg_we = 1'b0;
         repeat (gap - 1) @(negedge clk);
      end
   endtask

   task automatic cmp_q(string tag, int g[$], int e[$]);
      int bad = 0;
      chk(g.size() == e.size(), {tag, " count"}, g.size(), e.size());
      for (int i = 0; i < g.size() && i < e.size(); i++) if (g[i] != e[i]) bad++;
      chk(bad == 0, {tag, " bytes"}, bad, 0);
   endtask

   task automatic flush(string tag, bit runs);
      repeat (4) @(negedge clk);
      cmp_q({tag, " port0"}, got0, exp0);
      cmp_q({tag, " port1"}, got1, exp1);
      if (runs) begin
         cmp_q({tag, " port0 runs"}, run0, erun0);
         cmp_q({tag, " port1 runs"}, run1, erun1);
      end
      got0.delete(); got1.delete(); exp0.delete(); exp1.delete();
      run0.delete(); run1.delete(); erun0.delete(); erun1.delete();
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      #3000000;
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(!out0_valid && !out1_valid, "R1 valids low in reset", {out1_valid, out0_valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!out0_valid && !out1_valid, "R1 valids low after reset", {out1_valid, out0_valid}, 0);

      // R1 / R2: reset mode is off, packet goes to port 0
      send(8'h12, 5, 2, -1, 0, 1);
      flush("R1 reset mode", 1);

      // R3: both ports
      wr(0, 4);
      send(8'h01, 3, 1, -1, 0, 1);
      send(8'h7E, 17, 1);
      send(8'hC3, 31, 1);
      flush("R3 both", 1);

      // R4: masked address compare
      wr(0, 1); wr(2, 8'hA5); wr(3, 8'hF0);
      send(8'hA3, 6, 1);
      send(8'h35, 6, 1);
      wr(3, 0);
      send(8'h35, 4, 1);
      for (int k = 0; k < 15; k++) begin
         wr(2, int'($urandom_range(0, 255)));
         wr(3, int'($urandom_range(0, 255)));
         send(int'($urandom_range(0, 255)), int'($urandom_range(3, 31)), 1);
      end
      flush("R4 addr", 1);

      // R5: inclusive length window
      wr(0, 2); wr(4, 7); wr(5, 12);
      send(8'h10, 6, 1);
      send(8'h11, 7, 1);
      send(8'h12, 12, 1);
      send(8'h13, 13, 1);
      wr(4, 9); wr(5, 9);
      send(8'h14, 8, 1);
      send(8'h15, 9, 1);
      send(8'h16, 10, 1);
      for (int k = 0; k < 15; k++) begin
         int lo = int'($urandom_range(3, 31));
         wr(4, lo);
         wr(5, int'($urandom_range(lo, 31)));
         send(int'($urandom_range(0, 255)), int'($urandom_range(3, 31)), 1);
      end
      flush("R5 length", 1);

      // R2: undefined mode codes and mode 0
      wr(0, 3); send(8'h20, 5, 1);
      wr(0, 7); send(8'h21, 5, 1);
      wr(0, 255); send(8'h22, 5, 1);
      wr(0, 0); send(8'h23, 9, 1, -1, 0, 1);
      flush("R2 off", 1);

      // R7: writes inside a packet apply from the next packet
      wr(0, 1); wr(2, 8'h10); wr(3, 8'hFF);
      send(8'h10, 8, 1, 0, 0);
      send(8'h10, 8, 1);
      wr(0, 1);
      send(8'h10, 6, 1, 3, 8'h0F);
      send(8'h40, 6, 1);
      flush("R7 snapshot", 1);

      // R8: unused indices have no effect
      wr(0, 0); wr(1, 4); wr(6, 4); wr(7, 4);
      send(8'h55, 7, 1);
      wr(0, 4);
      send(8'h56, 7, 1);
      flush("R8 regs", 1);

      // R6: extreme lengths with timing probe
      wr(0, 2); wr(4, 31); wr(5, 31);
      send(8'h66, 3, 2, -1, 0, 1);
      send(8'h67, 31, 2, -1, 0, 1);
      flush("R6 framing", 1);

      // R9: zero-gap bursts
      for (int burst = 0; burst < 4; burst++) begin
         int md = int'($urandom_range(0, 3));
         md = (md == 3) ? 4 : md;
         wr(0, md);
         wr(2, int'($urandom_range(0, 255)));
         wr(3, int'($urandom_range(0, 255)));
         wr(4, int'($urandom_range(3, 15)));
         wr(5, int'($urandom_range(15, 31)));
         for (int k = 0; k < 12; k++)
            send(int'($urandom_range(0, 255)), int'($urandom_range(3, 31)), (k == 11) ? 1 : 0);
         flush("R9 back to back", 0);
      end

      finish_run();
   end
endmodule